// File: doc/BRIEF.md
# Fused-op align and pair stage

This front-end stage takes a 16-byte fetch block of internal RISC ops that are 16 or 32 bits long. It finds where each op starts and aligns it into a 32-bit word. An op that carries the fuse flag is joined with the op that follows it, and the two travel as one macro-op. Each cycle the stage presents up to three dispatch slots in program order. A slot holds either a single op or a fused head/tail pair. When a block yields more macro-ops than there are slots, the stage issues it over several cycles. While it does so, it holds off the fetch side with `fb_take_o`.

Every op starts with a 16-bit parcel. Bit 15 of that parcel is the fuse flag. Bit 14 is the length flag: 1 means the op is 32 bits long and also uses the next parcel. Parcel k of the block occupies bits `[16k+15:16k]` of `fb_data_i`. A 32-bit op is presented as `{second parcel, first parcel}`. A 16-bit op is zero-extended. A head whose tail would lie past the end of the block is held in a carry register and joined with the first op of the next block. When the block ends in a taken redirect, the fuse flag of its last op is ignored and that op is issued alone.

The controller has two states. In EMPTY no block is held and `fb_take_o` is high. EMPTY goes to ISSUE when `fb_valid_i` is high. In ISSUE the held block is presented one group of up to three macro-ops at a time. The stage advances to the next group when `dq_ready_i` is high, or at once when the group is empty. After the final group, ISSUE stays in ISSUE if a new block is offered in the same cycle, and otherwise returns to EMPTY. The carry register is updated when the final group leaves.

Top module: `fuse_align_stage`

## Requirements
- R1: After reset all slot valid flags are 0, `fb_take_o` is 1 and the carry register is empty.
- R2: A parcel whose bit 14 is 1 starts a 32-bit op, presented as {next parcel, this parcel} with its length flag set. A parcel whose bit 14 is 0 is a 16-bit op, presented as {16'h0, parcel} with its length flag clear. The second parcel of a 32-bit op never starts an op.
- R3: An op whose bit 15 is 1 is paired with the following op in one slot: `slot_fused_o` is 1, the op goes in the head fields and the follower goes in the tail fields. The tail's own bit 15 is ignored, so pairs never chain.
- R4: Macro-ops are issued in program order, lowest slot first, at most three per cycle. Valid slots are always a contiguous run starting at slot 0, and any further macro-ops follow in the next cycles.
- R5: Only parcels whose `fb_mask_i` bit is 1 are decoded, and decoding starts at the lowest such parcel. The mask must be one contiguous run.
- R6: When the last op of a block has bit 15 set and `fb_redirect_i` is 0, that op is not issued with the block. It is issued later as the head of slot 0, paired with the first op of the next block.
- R7: When `fb_redirect_i` is 1, the last op of the block is issued alone even if its bit 15 is set, and nothing is carried.
- R8: While a slot is valid and `dq_ready_i` is 0, all slot outputs hold their values and `fb_take_o` is 0.
- R9: `fb_take_o` is 1 whenever no block is held, and in the cycle the final group of a block is accepted. A block is loaded on a clock edge where both `fb_valid_i` and `fb_take_o` are 1.
- R10: A slot without a tail has `slot_fused_o` at 0 and its tail word and tail length flag at 0. An invalid slot has all of its fields at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fb_valid_i | input | 1 | Fetch block offered |
| fb_data_i | input | 128 | Fetch block, parcel k at bits [16k+15:16k] |
| fb_mask_i | input | 8 | Per-parcel valid mask |
| fb_redirect_i | input | 1 | Block ends in a taken redirect |
| fb_take_o | output | 1 | Stage accepts the offered block this cycle |
| dq_ready_i | input | 1 | Downstream accepts the presented slots |
| slot_valid_o | output | 3 | Slot holds a macro-op |
| slot_fused_o | output | 3 | Slot holds a head/tail pair |
| slot_head_o | output | 96 | Head word per slot, slot j at [32j+31:32j] |
| slot_head_long_o | output | 3 | Head is a 32-bit op |
| slot_tail_o | output | 96 | Tail word per slot |
| slot_tail_long_o | output | 3 | Tail is a 32-bit op |

## Verification
The hardest case to reach from the ports is a carried head. To get there, a block must end in a fused op with no redirect. That head must stay invisible while the stage drains and sits empty, and it must then come out paired in slot 0 of the next block. The bench drives exactly this sequence with two back-to-back blocks. It checks that all slots are empty between the two blocks, and then checks the pair. A stall is reached by dropping `dq_ready_i` before a block that needs two groups, and offering a second block during the stall. That second block must not be taken until the final group leaves.

// File: rtl/fas_pkg.sv
package fas_pkg;

    localparam int PW       = 16;        // parcel width
    localparam int WW       = 2 * PW;    // aligned op word width
    localparam int FUSE_BIT = 15;        // head-of-pair flag within the first parcel
    localparam int LONG_BIT = 14;        // 32-bit length flag within the first parcel

    typedef struct packed {
        logic [WW-1:0] word;
        logic          long_op;
        logic          fuse;
    } op_t;

    typedef struct packed {
        logic [WW-1:0] head;
        logic          head_long;
        logic          has_tail;
        logic [WW-1:0] tail;
        logic          tail_long;
    } mop_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_ISSUE = 1'b1
    } fas_state_e;

endpackage

// File: rtl/fas_boundary.sv
// Finds op start parcels in a masked block and aligns each op into one word.
module fas_boundary
    import fas_pkg::*;
#(
    parameter int PARCELS = 8
) (
    input  logic [PARCELS-1:0][PW-1:0] par_i,
    input  logic [PARCELS-1:0]         mask_i,
    output op_t  [PARCELS-1:0]         op_o,
    output logic [PARCELS-1:0]         start_o
);

    // One zero parcel past the end so a long op at the top index stays in range.
    logic [PARCELS:0][PW-1:0] par_x;
    assign par_x = {{PW{1'b0}}, par_i};

    always_comb begin
        logic second;
        second  = 1'b0;
        op_o    = '0;
        start_o = '0;
        for (int p = 0; p < PARCELS; p++) begin
            if (mask_i[p] && !second) begin
                start_o[p]      = 1'b1;
                op_o[p].fuse    = par_x[p][FUSE_BIT];
                op_o[p].long_op = par_x[p][LONG_BIT];
                if (par_x[p][LONG_BIT]) begin
                    op_o[p].word = {par_x[p+1], par_x[p]};
                end else begin
                    op_o[p].word = {{PW{1'b0}}, par_x[p]};
                end
                second = par_x[p][LONG_BIT];
            end else begin
                second = 1'b0;
            end
        end
    end

endmodule

// File: rtl/fas_pair.sv
// Walks the aligned ops in program order and forms single or fused macro-ops.
module fas_pair
    import fas_pkg::*;
#(
    parameter  int PARCELS = 8,
    localparam int CW      = $clog2(PARCELS + 1),
    localparam int AW      = $clog2(PARCELS)
) (
    input  op_t  [PARCELS-1:0] op_i,
    input  logic [PARCELS-1:0] start_i,
    input  logic               redirect_i,
    input  logic               carry_vld_i,
    input  op_t                carry_op_i,
    output mop_t [PARCELS-1:0] mop_o,
    output logic [CW-1:0]      mop_cnt_o,
    output logic               carry_vld_o,
    output op_t                carry_op_o
);

    logic [PARCELS-1:0] later_start;

    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int p = PARCELS - 1; p >= 0; p--) begin
            later_start[p] = seen;
            seen           = seen | start_i[p];
        end
    end

    always_comb begin
        logic    pend;
        op_t     head;
        logic [CW-1:0] cnt;
        pend  = carry_vld_i;
        head  = carry_op_i;
        cnt   = '0;
        mop_o = '0;
        for (int p = 0; p < PARCELS; p++) begin
            if (start_i[p]) begin
                if (pend) begin
                    mop_o[cnt[AW-1:0]].head      = head.word;
                    mop_o[cnt[AW-1:0]].head_long = head.long_op;
                    mop_o[cnt[AW-1:0]].has_tail  = 1'b1;
                    mop_o[cnt[AW-1:0]].tail      = op_i[p].word;
                    mop_o[cnt[AW-1:0]].tail_long = op_i[p].long_op;
                    cnt  = cnt + CW'(1);
                    pend = 1'b0;
                end else if (op_i[p].fuse && (later_start[p] || !redirect_i)) begin
                    pend = 1'b1;
                    head = op_i[p];
                end else begin
                    mop_o[cnt[AW-1:0]].head      = op_i[p].word;
                    mop_o[cnt[AW-1:0]].head_long = op_i[p].long_op;
                    cnt = cnt + CW'(1);
                end
            end
        end
        mop_cnt_o   = cnt;
        carry_vld_o = pend;
        carry_op_o  = pend ? head : '0;
    end

endmodule

// File: rtl/fas_slot_sel.sv
// Picks the current group of macro-ops into the dispatch slots.
module fas_slot_sel
    import fas_pkg::*;
#(
    parameter  int PARCELS = 8,
    parameter  int SLOTS   = 3,
    localparam int CW      = $clog2(PARCELS + 1),
    localparam int AW      = $clog2(PARCELS)
) (
    input  mop_t [PARCELS-1:0]  mop_i,
    input  logic [CW-1:0]       mop_cnt_i,
    input  logic [CW-1:0]       rd_ptr_i,
    output logic [SLOTS-1:0]    valid_o,
    output logic [SLOTS-1:0]    fused_o,
    output logic [SLOTS*WW-1:0] head_o,
    output logic [SLOTS-1:0]    head_long_o,
    output logic [SLOTS*WW-1:0] tail_o,
    output logic [SLOTS-1:0]    tail_long_o,
    output logic                last_grp_o
);

    assign last_grp_o = ({1'b0, rd_ptr_i} + (CW+1)'(SLOTS)) >= {1'b0, mop_cnt_i};

    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
        logic [CW:0] pos;
        mop_t        sel;
        assign pos = {1'b0, rd_ptr_i} + (CW+1)'(j);

        always_comb begin
            if (pos < {1'b0, mop_cnt_i}) begin
                sel        = mop_i[pos[AW-1:0]];
                valid_o[j] = 1'b1;
            end else begin
                sel        = '0;
                valid_o[j] = 1'b0;
            end
        end

        assign fused_o[j]           = sel.has_tail;
        assign head_o[j*WW +: WW]   = sel.head;
        assign head_long_o[j]       = sel.head_long;
        assign tail_o[j*WW +: WW]   = sel.tail;
        assign tail_long_o[j]       = sel.tail_long;
    end

endmodule

// File: rtl/fuse_align_stage.sv
module fuse_align_stage
    import fas_pkg::*;
#(
    parameter  int PARCELS = 8,
    parameter  int SLOTS   = 3,
    localparam int BLK_W   = PARCELS * PW,
    localparam int CW      = $clog2(PARCELS + 1)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 fb_valid_i,
    input  logic [BLK_W-1:0]     fb_data_i,
    input  logic [PARCELS-1:0]   fb_mask_i,
    input  logic                 fb_redirect_i,
    output logic                 fb_take_o,
    input  logic                 dq_ready_i,
    output logic [SLOTS-1:0]     slot_valid_o,
    output logic [SLOTS-1:0]     slot_fused_o,
    output logic [SLOTS*WW-1:0]  slot_head_o,
    output logic [SLOTS-1:0]     slot_head_long_o,
    output logic [SLOTS*WW-1:0]  slot_tail_o,
    output logic [SLOTS-1:0]     slot_tail_long_o
);

    fas_state_e state_q, state_d;

    logic [PARCELS-1:0][PW-1:0] blk_par_q;
    logic [PARCELS-1:0]         blk_mask_q;
    logic                       blk_redir_q;
    logic [CW-1:0]              rd_ptr_q;
    logic                       carry_vld_q;
    op_t                        carry_op_q;

    op_t  [PARCELS-1:0] ops;
    logic [PARCELS-1:0] starts;
    mop_t [PARCELS-1:0] mops;
    logic [CW-1:0]      mop_cnt;
    logic [CW-1:0]      mop_cnt_eff;
    logic               carry_vld_nxt;
    op_t                carry_op_nxt;
    logic               last_grp;
    logic               fire;
    logic               done;
    logic               load;

    fas_boundary #(.PARCELS(PARCELS)) u_bound (
        .par_i   (blk_par_q),
        .mask_i  (blk_mask_q),
        .op_o    (ops),
        .start_o (starts)
    );

    fas_pair #(.PARCELS(PARCELS)) u_pair (
        .op_i        (ops),
        .start_i     (starts),
        .redirect_i  (blk_redir_q),
        .carry_vld_i (carry_vld_q),
        .carry_op_i  (carry_op_q),
        .mop_o       (mops),
        .mop_cnt_o   (mop_cnt),
        .carry_vld_o (carry_vld_nxt),
        .carry_op_o  (carry_op_nxt)
    );

    assign mop_cnt_eff = (state_q == ST_ISSUE) ? mop_cnt : '0;

    fas_slot_sel #(.PARCELS(PARCELS), .SLOTS(SLOTS)) u_sel (
        .mop_i       (mops),
        .mop_cnt_i   (mop_cnt_eff),
        .rd_ptr_i    (rd_ptr_q),
        .valid_o     (slot_valid_o),
        .fused_o     (slot_fused_o),
        .head_o      (slot_head_o),
        .head_long_o (slot_head_long_o),
        .tail_o      (slot_tail_o),
        .tail_long_o (slot_tail_long_o),
        .last_grp_o  (last_grp)
    );

    // Group handshake: an empty group leaves without waiting for downstream.
    always_comb begin
        fire      = (state_q == ST_ISSUE) && (dq_ready_i || (slot_valid_o == '0));
        done      = fire && last_grp;
        fb_take_o = (state_q == ST_EMPTY) || done;
        load      = fb_valid_i && fb_take_o;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (fb_valid_i) state_d = ST_ISSUE;
            ST_ISSUE: if (done)       state_d = fb_valid_i ? ST_ISSUE : ST_EMPTY;
            default:                  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_EMPTY;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            blk_par_q   <= '0;
            blk_mask_q  <= '0;
            blk_redir_q <= 1'b0;
            rd_ptr_q    <= '0;
            carry_vld_q <= 1'b0;
            carry_op_q  <= '0;
        end else begin
            if (load) begin
                blk_par_q   <= fb_data_i;
                blk_mask_q  <= fb_mask_i;
                blk_redir_q <= fb_redirect_i;
                rd_ptr_q    <= '0;
            end else if (fire && !done) begin
                rd_ptr_q    <= rd_ptr_q + CW'(SLOTS);
            end
            if (done) begin
                carry_vld_q <= carry_vld_nxt;
                carry_op_q  <= carry_op_nxt;
            end
        end
    end

endmodule

// File: rtl/fas_chk.sv
module fas_chk #(
    parameter int SLOTS = 3,
    parameter int WW    = 32
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                fb_take_o,
    input logic                dq_ready_i,
    input logic [SLOTS-1:0]    slot_valid_o,
    input logic [SLOTS-1:0]    slot_fused_o,
    input logic [SLOTS*WW-1:0] slot_head_o,
    input logic [SLOTS-1:0]    slot_head_long_o,
    input logic [SLOTS*WW-1:0] slot_tail_o,
    input logic [SLOTS-1:0]    slot_tail_long_o
);

    a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((slot_valid_o != '0) && !dq_ready_i) |=>
            ($stable(slot_valid_o) && $stable(slot_fused_o) &&
             $stable(slot_head_o) && $stable(slot_tail_o)));

    a_r8_no_take_in_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((slot_valid_o != '0) && !dq_ready_i) |-> !fb_take_o);

    a_r4_slots_packed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((slot_valid_o + SLOTS'(1)) & slot_valid_o) == '0);

    a_r10_fused_within_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_fused_o & ~slot_valid_o) == '0);

    a_r9_take_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_valid_o == '0) |-> fb_take_o);

    for (genvar j = 0; j < SLOTS; j++) begin : g_slot_chk
        a_r10_tail_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !slot_fused_o[j] |-> ((slot_tail_o[j*WW +: WW] == '0) && !slot_tail_long_o[j]));

        a_r2_short_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (slot_valid_o[j] && !slot_head_long_o[j]) |-> (slot_head_o[j*WW+WW/2 +: WW/2] == '0));
    end

endmodule

bind fuse_align_stage fas_chk #(.SLOTS(SLOTS), .WW(fas_pkg::WW)) u_fas_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .fb_take_o        (fb_take_o),
    .dq_ready_i       (dq_ready_i),
    .slot_valid_o     (slot_valid_o),
    .slot_fused_o     (slot_fused_o),
    .slot_head_o      (slot_head_o),
    .slot_head_long_o (slot_head_long_o),
    .slot_tail_o      (slot_tail_o),
    .slot_tail_long_o (slot_tail_long_o)
);

// File: tb/fuse_align_stage_tb_top.sv
`timescale 1ns/1ps
module fuse_align_stage_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fb_valid = 1'b0;
    logic [127:0] fb_data = '0;
    logic [7:0]   fb_mask = '0;
    logic         fb_redir = 1'b0;
    logic         fb_take;
    logic         dq_ready = 1'b1;
    logic [2:0]   s_valid, s_fused, s_hlong, s_tlong;
    logic [95:0]  s_head, s_tail;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    fuse_align_stage dut_i (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .fb_valid_i       (fb_valid),
        .fb_data_i        (fb_data),
        .fb_mask_i        (fb_mask),
        .fb_redirect_i    (fb_redir),
        .fb_take_o        (fb_take),
        .dq_ready_i       (dq_ready),
        .slot_valid_o     (s_valid),
        .slot_fused_o     (s_fused),
        .slot_head_o      (s_head),
        .slot_head_long_o (s_hlong),
        .slot_tail_o      (s_tail),
        .slot_tail_long_o (s_tlong)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One slot: {valid, head, head_long, fused, tail, tail_long}
    task automatic chk_slot(input string tag, input int j, input logic v,
                            input logic [31:0] hw, input logic hl, input logic f,
                            input logic [31:0] tw, input logic tl);
        check(tag, {s_valid[j], s_head[j*32 +: 32], s_hlong[j], s_fused[j], s_tail[j*32 +: 32], s_tlong[j]},
                   {v, hw, hl, f, tw, tl});
    endtask

    task automatic chk_empty(input string tag, input int j);
        chk_slot(tag, j, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0);
    endtask

    // Offer a block, wait until taken, return at the negedge after loading.
    task automatic load(input logic [7:0][15:0] pk, input logic [7:0] m, input logic r);
        @(negedge clk);
        fb_valid = 1'b1; fb_data = pk; fb_mask = m; fb_redir = r;
        while (!fb_take) @(negedge clk);
        @(negedge clk);
        fb_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 slots idle after reset", {125'h0, s_valid}, 128'h0);
        check("R1 R9 take high after reset", {127'h0, fb_take}, 128'h1);
    endtask

    task automatic t_lengths();
        logic [7:0][15:0] pk;
        pk[0] = 16'h0111; pk[1] = 16'h4222; pk[2] = 16'hBEEF; pk[3] = 16'h0333;
        pk[4] = 16'h0444; pk[5] = 16'h4555; pk[6] = 16'h1234; pk[7] = 16'h0666;
        load(pk, 8'hFF, 1'b0);
        chk_slot("R2 R4 grp0 s0 short", 0, 1, 32'h0000_0111, 0, 0, 0, 0);
        chk_slot("R2 R4 grp0 s1 long",  1, 1, 32'hBEEF_4222, 1, 0, 0, 0);
        chk_slot("R2 R4 grp0 s2 short", 2, 1, 32'h0000_0333, 0, 0, 0, 0);
        @(negedge clk);
        chk_slot("R4 grp1 s0", 0, 1, 32'h0000_0444, 0, 0, 0, 0);
        chk_slot("R2 R4 grp1 s1 long", 1, 1, 32'h1234_4555, 1, 0, 0, 0);
        chk_slot("R4 grp1 s2", 2, 1, 32'h0000_0666, 0, 0, 0, 0);
        @(negedge clk);
        check("R9 drained block leaves idle", {126'h0, s_valid != 0, fb_take}, 128'h1);
    endtask

    task automatic t_fuse();
        logic [7:0][15:0] pk;
        pk[0] = 16'h8011; pk[1] = 16'h0022; pk[2] = 16'hC033; pk[3] = 16'h0A0A;
        pk[4] = 16'h8044; pk[5] = 16'h0055; pk[6] = 16'h8066; pk[7] = 16'h0077;
        load(pk, 8'hFF, 1'b0);
        chk_slot("R3 short pair", 0, 1, 32'h0000_8011, 0, 1, 32'h0000_0022, 0);
        chk_slot("R3 long head pair", 1, 1, 32'h0A0A_C033, 1, 1, 32'h0000_8044, 0);
        chk_slot("R3 tail fuse ignored, next op alone", 2, 1, 32'h0000_0055, 0, 0, 0, 0);
        @(negedge clk);
        chk_slot("R3 R4 last pair in next group", 0, 1, 32'h0000_8066, 0, 1, 32'h0000_0077, 0);
        chk_empty("R10 unused slot 1 clear", 1);
        chk_empty("R10 unused slot 2 clear", 2);
        @(negedge clk);
    endtask

    task automatic t_mask();
        logic [7:0][15:0] pk;
        pk[0] = 16'hC0FF; pk[1] = 16'h8001; pk[2] = 16'h4ABC; pk[3] = 16'hDEAD;
        pk[4] = 16'h0011; pk[5] = 16'h0022; pk[6] = 16'h8099; pk[7] = 16'h4000;
        load(pk, 8'h3C, 1'b0);
        chk_slot("R5 first valid parcel long", 0, 1, 32'hDEAD_4ABC, 1, 0, 0, 0);
        chk_slot("R5 mid op", 1, 1, 32'h0000_0011, 0, 0, 0, 0);
        chk_slot("R5 last masked-in op", 2, 1, 32'h0000_0022, 0, 0, 0, 0);
        @(negedge clk);
        check("R5 masked-out parcels not issued", {125'h0, s_valid}, 128'h0);
    endtask

    task automatic t_carry();
        logic [7:0][15:0] pk;
        pk = '0;
        pk[0] = 16'h0101; pk[1] = 16'h0202; pk[2] = 16'h0303; pk[3] = 16'h8404;
        load(pk, 8'h0F, 1'b0);
        chk_slot("R6 s0", 0, 1, 32'h0000_0101, 0, 0, 0, 0);
        chk_slot("R6 s2", 2, 1, 32'h0000_0303, 0, 0, 0, 0);
        @(negedge clk);
        check("R6 carried head not issued alone", {125'h0, s_valid}, 128'h0);
        pk = '0;
        pk[0] = 16'h0505; pk[1] = 16'h0606;
        load(pk, 8'h03, 1'b0);
        chk_slot("R6 carried head pairs in slot 0", 0, 1, 32'h0000_8404, 0, 1, 32'h0000_0505, 0);
        chk_slot("R6 following op", 1, 1, 32'h0000_0606, 0, 0, 0, 0);
        chk_empty("R6 slot 2 empty", 2);
        @(negedge clk);
    endtask

    task automatic t_redirect();
        logic [7:0][15:0] pk;
        pk = '0;
        pk[0] = 16'h0707; pk[1] = 16'h8808;
        load(pk, 8'h03, 1'b1);
        chk_slot("R7 first op", 0, 1, 32'h0000_0707, 0, 0, 0, 0);
        chk_slot("R7 fused last op issued alone", 1, 1, 32'h0000_8808, 0, 0, 0, 0);
        @(negedge clk);
        pk = '0;
        pk[0] = 16'h0909;
        load(pk, 8'h01, 1'b0);
        chk_slot("R7 nothing carried past redirect", 0, 1, 32'h0000_0909, 0, 0, 0, 0);
        @(negedge clk);
    endtask

    task automatic t_stall();
        logic [7:0][15:0] pk;
        logic [95:0] h0;
        logic [2:0]  v0;
        pk[0] = 16'h0111; pk[1] = 16'h4222; pk[2] = 16'hBEEF; pk[3] = 16'h0333;
        pk[4] = 16'h0444; pk[5] = 16'h4555; pk[6] = 16'h1234; pk[7] = 16'h0666;
        dq_ready = 1'b0;
        load(pk, 8'hFF, 1'b0);
        h0 = s_head; v0 = s_valid;
        pk = '0; pk[0] = 16'h0A0A;
        fb_valid = 1'b1; fb_data = pk; fb_mask = 8'h01; fb_redir = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 slots hold during stall", {29'h0, s_valid, s_head}, {29'h0, v0, h0});
            check("R8 R9 no take during stall", {127'h0, fb_take}, 128'h0);
        end
        dq_ready = 1'b1;
        @(negedge clk);
        chk_slot("R8 resumes with next group", 0, 1, 32'h0000_0444, 0, 0, 0, 0);
        check("R9 take with final group", {127'h0, fb_take}, 128'h1);
        @(negedge clk);
        fb_valid = 1'b0;
        chk_slot("R9 pending block loaded", 0, 1, 32'h0000_0A0A, 0, 0, 0, 0);
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_lengths();
        t_fuse();
        t_mask();
        t_carry();
        t_redirect();
        t_stall();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule